// File: doc/BRIEF.md
# DRAM Controller Event Counter Unit

This block watches a DRAM controller and counts what it does. It has a small set of counters, four by default. Counter 0 always counts clock cycles and acts as the master for the whole unit. Each of the other counters counts one event, chosen by an 8-bit code. The events arrive as single-cycle strobes on a 255-bit input vector, where bit k carries event code k.

Two codes are special. Code 0x41 counts AXI read transactions and code 0x42 counts AXI write transactions. Both count only transactions whose ID passes one shared, masked ID filter. When the enhanced option is built in, a counter on either code also keeps a running total of the bytes those transactions carried.

Software uses a plain word-wide register port with writes and combinational reads. The only interrupt comes from the cycle counter: when it wraps, every counter stops until software acknowledges it. This lets software read all counters before the cycle count is lost.

Top module: `dram_evmon`

## Requirements
- R1: After reset, every control word, every count, every byte total and the filter word read as zero, and `irq_o` is low.
- R2: Counter 0 adds one on every clock while its enable bit (bit 2) is set and its overflow flag is clear. Its select field (bits 31:24) always reads 0, and any select value written to it is ignored.
- R3: Counter n (n ≥ 1) adds one for each cycle in which `ev_i[sel]` is high. It counts only while its own enable bit and counter 0's enable bit are both set. Clearing counter 0's enable freezes counters 1..N-1, and setting it again lets them resume.
- R4: When counter 0 wraps from all-ones to zero, it sets its overflow flag (bit 0) and raises `irq_o`. From the next cycle on, every counter holds its value until that flag is cleared.
- R5: Counters 1..N-1 are CTR_W bits wide and wrap modulo 2^CTR_W. On a wrap a counter sets its own overflow flag (bit 0), but it raises no interrupt and stops no counter.
- R6: `irq_o` is a level that follows counter 0's overflow flag. Writing 0 to bit 0 of control word 0 clears it. Writing 1 to bit 0 leaves any overflow flag unchanged.
- R7: For counters 1..N-1, a control write with bit 1 = 0 sets the count and byte total to zero. After any such write, bit 1 reads back as 1.
- R8: Counter 0 clears only when bit 1 is written as 1 and the stored bit 1 was 0. Bit 1 of control word 0 reads back the value last written.
- R9: In a cycle where software writes control word n, counter n does not advance, even if its event strobe is high.
- R10: The filter word sits at byte offset 0x30. Bits 15:0 hold the ID and bits 31:16 hold a stored mask. A transaction ID passes when `(id ^ flt_id) & ~stored_mask` is zero, so a stored mask bit of 1 means that ID bit is ignored. Code 0x41 counts `ev_i[0x41]` strobes whose `rd_id_i` passes. Code 0x42 counts `ev_i[0x42]` strobes whose `wr_id_i` passes.
- R11: With ENHANCED=1, byte offset 0x30+4n (n ≥ 1) reads counter n's byte total. Each counted transaction adds `rd_bytes_i` under code 0x41 or `wr_bytes_i` under code 0x42. Under any other code the total stays 0.
- R12: Control word n is at byte offset 4n and the live count of counter n is at 0x20+4n, zero-extended to 32 bits. An address with bits 1:0 not zero, or outside the map, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| ev_i | input | 255 | Event strobes; bit k is event code k (k = 1..255) |
| rd_id_i | input | ID_W | ID of the read transaction strobed on `ev_i[0x41]` |
| rd_bytes_i | input | XB_W | Byte size of that read transaction |
| wr_id_i | input | ID_W | ID of the write transaction strobed on `ev_i[0x42]` |
| wr_bytes_i | input | XB_W | Byte size of that write transaction |
| irq_o | output | 1 | Level interrupt from the cycle counter's overflow |

## Verification
The bench builds the unit with four counters, the enhanced byte path on, and CTR_W lowered to 10. At that width the cycle counter wraps after 1024 cycles. This puts the freeze, the interrupt hold and release, and the silent wrap of an event counter within a short run. The same counters still cover the two clear schemes, the write-over-strobe priority, enable gating by counter 0, and masked ID matching with byte totals.

// File: rtl/evmon_pkg.sv
`timescale 1ns/1ps
package evmon_pkg;
   localparam int unsigned SEL_W     = 8;
   localparam int unsigned NUM_CODES = 1 << SEL_W;

   localparam logic [SEL_W-1:0] CODE_CYCLES = 8'h00;
   localparam logic [SEL_W-1:0] CODE_AXI_RD = 8'h41;
   localparam logic [SEL_W-1:0] CODE_AXI_WR = 8'h42;

   // control word bit positions (software relies on them)
   localparam int unsigned BIT_OVF = 0;
   localparam int unsigned BIT_CLR = 1;
   localparam int unsigned BIT_EN  = 2;
   localparam int unsigned SEL_LSB = 24;

   // word offsets of the register regions
   localparam int WORD_CTL = 0;
   localparam int WORD_CNT = 8;
   localparam int WORD_FLT = 12;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             en;
      logic             clr;
      logic             ovf;
   } ctl_t;

   function automatic logic [31:0] pack_ctl(ctl_t c);
      logic [31:0] w;
      w = '0;
      w[SEL_LSB +: SEL_W] = c.sel;
      w[BIT_EN]           = c.en;
      w[BIT_CLR]          = c.clr;
      w[BIT_OVF]          = c.ovf;
      return w;
   endfunction
endpackage

// File: rtl/evmon_idfilter.sv
`timescale 1ns/1ps
module evmon_idfilter #(
   parameter int unsigned ID_W = 16
) (
   input  logic [ID_W-1:0] flt_id_i,
   input  logic [ID_W-1:0] flt_ign_i,
   input  logic [ID_W-1:0] rd_id_i,
   input  logic [ID_W-1:0] wr_id_i,
   output logic            rd_pass_o,
   output logic            wr_pass_o
);
   function automatic logic id_pass(logic [ID_W-1:0] id,
                                    logic [ID_W-1:0] ref_id,
                                    logic [ID_W-1:0] ign);
      return ((id ^ ref_id) & ~ign) == '0;
   endfunction

   assign rd_pass_o = id_pass(rd_id_i, flt_id_i, flt_ign_i);
   assign wr_pass_o = id_pass(wr_id_i, flt_id_i, flt_ign_i);
endmodule

// File: rtl/evmon_slice.sv
`timescale 1ns/1ps
module evmon_slice
   import evmon_pkg::*;
#(
   parameter int unsigned CTR_W    = 32,
   parameter int unsigned XB_W     = 13,
   parameter bit          IS_CYCLE = 1'b0,
   parameter bit          ENHANCED = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_i,
   input  ctl_t                 wr_ctl_i,
   input  logic                 run_i,
   input  logic [NUM_CODES-1:0] ev_all_i,
   input  logic [XB_W-1:0]      rd_bytes_i,
   input  logic [XB_W-1:0]      wr_bytes_i,
   output ctl_t                 ctl_o,
   output logic [CTR_W-1:0]     cnt_o,
   output logic [CTR_W-1:0]     bytes_o
);
   logic [SEL_W-1:0] sel_q;
   logic             en_q, clr_q, ovf_q;
   logic [CTR_W-1:0] cnt_q;
   logic             hit, adv, wrap, clr_pulse, clr_nxt;

   assign hit  = ev_all_i[sel_q];
   assign adv  = run_i & en_q & hit & ~wr_i;
   assign wrap = adv & (cnt_q == '1);

   if (IS_CYCLE) begin : g_cyc_clr
      assign clr_pulse = wr_i & wr_ctl_i.clr & ~clr_q;
      assign clr_nxt   = wr_ctl_i.clr;
   end else begin : g_evt_clr
      assign clr_pulse = wr_i & ~wr_ctl_i.clr;
      assign clr_nxt   = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= '0;
         en_q  <= 1'b0;
         clr_q <= 1'b0;
         ovf_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (wr_i) begin
            sel_q <= IS_CYCLE ? CODE_CYCLES : wr_ctl_i.sel;
            en_q  <= wr_ctl_i.en;
            clr_q <= clr_nxt;
            ovf_q <= ovf_q & wr_ctl_i.ovf;
         end else if (wrap) begin
            ovf_q <= 1'b1;
         end
         if (clr_pulse)  cnt_q <= '0;
         else if (adv)   cnt_q <= cnt_q + CTR_W'(1);
      end
   end

   if (ENHANCED) begin : g_bytes
      logic [CTR_W-1:0] byte_q, add;
      always_comb begin
         add = '0;
         if (sel_q == CODE_AXI_RD)      add = CTR_W'(rd_bytes_i);
         else if (sel_q == CODE_AXI_WR) add = CTR_W'(wr_bytes_i);
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        byte_q <= '0;
         else if (clr_pulse) byte_q <= '0;
         else if (adv)       byte_q <= byte_q + add;
      end
      assign bytes_o = byte_q;
   end else begin : g_no_bytes
      assign bytes_o = '0;
   end

   assign ctl_o = '{sel: sel_q, en: en_q, clr: clr_q, ovf: ovf_q};
   assign cnt_o = cnt_q;

   assert_wr_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == '0));
   assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !wr_i) |=> $stable(cnt_q));
   assert_wrap_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && cnt_q == '1) |=> (ovf_q && cnt_q == '0));
endmodule

// File: rtl/dram_evmon.sv
`timescale 1ns/1ps
module dram_evmon
   import evmon_pkg::*;
#(
   parameter int unsigned NUM_CTR  = 4,
   parameter int unsigned CTR_W    = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned ID_W     = 16,
   parameter int unsigned XB_W     = 13,
   parameter bit          ENHANCED = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 reg_we_i,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic [31:0]          reg_wdata_i,
   output logic [31:0]          reg_rdata_o,
   input  logic [NUM_CODES-1:1] ev_i,
   input  logic [ID_W-1:0]      rd_id_i,
   input  logic [XB_W-1:0]      rd_bytes_i,
   input  logic [ID_W-1:0]      wr_id_i,
   input  logic [XB_W-1:0]      wr_bytes_i,
   output logic                 irq_o
);
   localparam int unsigned WIDX_W = ADDR_W - 2;

   if (NUM_CTR < 2 || NUM_CTR > 4) begin : g_bad_num
      $error("dram_evmon: NUM_CTR must be 2..4");
   end
   if (CTR_W < 2 || CTR_W > 32) begin : g_bad_w
      $error("dram_evmon: CTR_W must be 2..32");
   end
   if (ID_W < 1 || ID_W > 16) begin : g_bad_id
      $error("dram_evmon: ID_W must be 1..16");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("dram_evmon: ADDR_W must be at least 6");
   end

   logic [WIDX_W-1:0]  word;
   logic               aligned, flt_we;
   logic [NUM_CTR-1:0] ctl_we, en_a, ovf_a;
   logic [31:0]        flt_q;
   ctl_t               wr_ctl;
   ctl_t               ctl_a  [NUM_CTR];
   logic [CTR_W-1:0]   cnt_a  [NUM_CTR];
   logic [CTR_W-1:0]   byte_a [NUM_CTR];
   logic               rd_pass, wr_pass;
   logic [NUM_CODES-1:0] ev_all;

   assign word    = reg_addr_i[ADDR_W-1:2];
   assign aligned = (reg_addr_i[1:0] == 2'b00);
   assign flt_we  = reg_we_i & aligned & (int'(word) == WORD_FLT);

   assign wr_ctl = '{sel: reg_wdata_i[SEL_LSB +: SEL_W],
                     en:  reg_wdata_i[BIT_EN],
                     clr: reg_wdata_i[BIT_CLR],
                     ovf: reg_wdata_i[BIT_OVF]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flt_q <= '0;
      else if (flt_we) flt_q <= reg_wdata_i;
   end

   evmon_idfilter #(.ID_W(ID_W)) u_filter (
      .flt_id_i  (flt_q[ID_W-1:0]),
      .flt_ign_i (flt_q[16 +: ID_W]),
      .rd_id_i   (rd_id_i),
      .wr_id_i   (wr_id_i),
      .rd_pass_o (rd_pass),
      .wr_pass_o (wr_pass)
   );

   always_comb begin
      ev_all = {ev_i, 1'b1};
      ev_all[CODE_AXI_RD] = ev_i[CODE_AXI_RD] & rd_pass;
      ev_all[CODE_AXI_WR] = ev_i[CODE_AXI_WR] & wr_pass;
   end

   for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
      logic run;
      assign ctl_we[n] = reg_we_i & aligned & (int'(word) == WORD_CTL + n);
      if (n == 0) begin : g_master
         assign run = ~ovf_a[0];
      end else begin : g_follower
         assign run = en_a[0] & ~ovf_a[0];
      end
      evmon_slice #(
         .CTR_W    (CTR_W),
         .XB_W     (XB_W),
         .IS_CYCLE (n == 0),
         .ENHANCED (ENHANCED)
      ) u_slice (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .wr_i       (ctl_we[n]),
         .wr_ctl_i   (wr_ctl),
         .run_i      (run),
         .ev_all_i   (ev_all),
         .rd_bytes_i (rd_bytes_i),
         .wr_bytes_i (wr_bytes_i),
         .ctl_o      (ctl_a[n]),
         .cnt_o      (cnt_a[n]),
         .bytes_o    (byte_a[n])
      );
      assign en_a[n]  = ctl_a[n].en;
      assign ovf_a[n] = ctl_a[n].ovf;
   end

   always_comb begin
      reg_rdata_o = '0;
      if (aligned) begin
         for (int n = 0; n < NUM_CTR; n++) begin
            if (int'(word) == WORD_CTL + n) reg_rdata_o = pack_ctl(ctl_a[n]);
            if (int'(word) == WORD_CNT + n) reg_rdata_o = 32'(cnt_a[n]);
            if (int'(word) == WORD_FLT + n)
               reg_rdata_o = (n == 0) ? flt_q : 32'(byte_a[n]);
         end
      end
   end

   assign irq_o = ovf_a[0];

   assert_irq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !(ctl_we[0] && !reg_wdata_i[BIT_OVF])) |=> irq_o);
   assert_irq_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(en_a[0]));
   assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !ctl_we[1]) |=> $stable(cnt_a[1]));
endmodule

// File: tb/dram_evmon_tb_top.sv
`timescale 1ns/1ps
module dram_evmon_tb_top;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         we = 1'b0;
   logic [7:0]   addr = '0;
   logic [31:0]  wdata = '0;
   logic [31:0]  rdata;
   logic [255:1] ev = '0;
   logic [15:0]  rid = '0, wid = '0;
   logic [12:0]  rby = '0, wby = '0;
   logic         irq;
   int           total = 0, bad = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   dram_evmon #(.NUM_CTR(4), .CTR_W(W), .ADDR_W(8), .ID_W(16), .XB_W(13),
                .ENHANCED(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ev_i(ev),
      .rd_id_i(rid), .rd_bytes_i(rby), .wr_id_i(wid), .wr_bytes_i(wby),
      .irq_o(irq));

   function automatic logic [7:0] a_ctl(int n); return 8'(4 * n); endfunction
   function automatic logic [7:0] a_cnt(int n); return 8'(32 + 4 * n); endfunction
   function automatic logic [7:0] a_byt(int n); return 8'(48 + 4 * n); endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic chk_reg(string tag, logic [7:0] a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic pulse(int b, int n);
      for (int i = 0; i < n; i++) begin
         ev[b] = 1'b1; @(negedge clk);
         ev[b] = 1'b0; @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; we = 1'b0; ev = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic arm(int n, logic [31:0] v);
      wr(a_ctl(n), 32'h0);
      wr(a_ctl(n), v);
   endtask

   task automatic t_reset_state();
      do_reset();
      for (int n = 0; n < 4; n++) begin
         chk_reg("R1 ctl", a_ctl(n), 0);
         chk_reg("R1 cnt", a_cnt(n), 0);
      end
      chk_reg("R1 filter/byte", 8'h30, 0);
      chk_reg("R1 bytes", a_byt(2), 0);
      chk("R1 irq", {31'b0, irq}, 0);
      wr(8'h01, 32'h6);
      chk_reg("R12 unaligned write ignored", a_ctl(0), 0);
      repeat (10) @(negedge clk);
      chk_reg("R2 disabled cycle counter", a_cnt(0), 0);
      chk_reg("R12 unmapped read", 8'h40, 0);
      chk_reg("R12 unaligned read", 8'h22, 0);
   endtask

   task automatic t_cycle();
      do_reset();
      arm(0, 32'h0400_0006);
      chk_reg("R2 select forced zero", a_ctl(0), 32'h0000_0006);
      pulse(4, 3);
      chk_reg("R2 counts every cycle", a_cnt(0), 6);
   endtask

   task automatic t_gate();
      logic [31:0] v;
      do_reset();
      arm(0, 32'h6);
      arm(1, 32'h0400_0006);
      arm(2, 32'h0500_0006);
      wr(a_ctl(3), 32'h0400_0000);
      pulse(4, 5);
      pulse(5, 2);
      chk_reg("R3 counter1 code 0x04", a_cnt(1), 5);
      chk_reg("R3 counter2 code 0x05", a_cnt(2), 2);
      chk_reg("R3 disabled counter3", a_cnt(3), 0);
      wr(a_ctl(0), 32'h2);
      rd(a_cnt(0), v);
      pulse(4, 3);
      chk_reg("R3 frozen by master disable", a_cnt(1), 5);
      chk_reg("R3 master holds when disabled", a_cnt(0), v);
      wr(a_ctl(0), 32'h6);
      pulse(4, 4);
      chk_reg("R3 resumes after master enable", a_cnt(1), 9);
      chk_reg("R3 counter2 unaffected", a_cnt(2), 2);
   endtask

   task automatic rtxn(logic [15:0] id, logic [12:0] by);
      ev[8'h41] = 1'b1; rid = id; rby = by;
      @(negedge clk);
      ev[8'h41] = 1'b0;
      @(negedge clk);
   endtask

   task automatic wtxn(logic [15:0] id, logic [12:0] by);
      ev[8'h42] = 1'b1; wid = id; wby = by;
      @(negedge clk);
      ev[8'h42] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_filter();
      do_reset();
      arm(0, 32'h6);
      arm(1, 32'h0400_0006);
      arm(2, 32'h4100_0006);
      arm(3, 32'h4200_0006);
      wr(8'h30, 32'h000F_1230);
      chk_reg("R10 filter readback", 8'h30, 32'h000F_1230);
      rtxn(16'h1235, 13'd16);
      rtxn(16'h1335, 13'd32);
      rtxn(16'h123F, 13'd8);
      rtxn(16'h0230, 13'd100);
      wtxn(16'h1230, 13'd64);
      wtxn(16'h2230, 13'd64);
      wtxn(16'h123A, 13'd4);
      chk_reg("R10 masked read matches", a_cnt(2), 2);
      chk_reg("R10 masked write matches", a_cnt(3), 2);
      chk_reg("R11 read byte total", a_byt(2), 24);
      chk_reg("R11 write byte total", a_byt(3), 68);
      chk_reg("R11 no bytes for plain code", a_byt(1), 0);
      chk_reg("R10 plain counter idle", a_cnt(1), 0);
      wr(a_ctl(2), 32'h4100_0004);
      chk_reg("R7 clear zeroes byte total", a_byt(2), 0);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      do_reset();
      arm(0, 32'h6);
      arm(1, 32'h0400_0006);
      pulse(4, 3);
      chk_reg("R7 before clear", a_cnt(1), 3);
      wr(a_ctl(1), 32'h0400_0004);
      chk_reg("R7 clear on zero", a_cnt(1), 0);
      chk_reg("R7 clear bit reads one", a_ctl(1), 32'h0400_0006);
      pulse(4, 2);
      wr(a_ctl(1), 32'h0400_0006);
      chk_reg("R7 write of one keeps count", a_cnt(1), 2);
      ev[4] = 1'b1;
      wr(a_ctl(1), 32'h0400_0006);
      ev[4] = 1'b0;
      chk_reg("R9 write beats strobe", a_cnt(1), 2);
      ev[4] = 1'b1;
      wr(a_ctl(1), 32'h0400_0004);
      ev[4] = 1'b0;
      chk_reg("R9 clear beats strobe", a_cnt(1), 0);
      rd(a_cnt(0), v);
      wr(a_ctl(0), 32'h4);
      chk_reg("R8 zero does not clear cycles", a_cnt(0), v);
      chk_reg("R8 clear bit stored as written", a_ctl(0), 32'h4);
      wr(a_ctl(0), 32'h6);
      chk_reg("R8 rising clear bit", a_cnt(0), 0);
      repeat (10) @(negedge clk);
      wr(a_ctl(0), 32'h6);
      chk_reg("R8 steady clear bit", a_cnt(0), 10);
   endtask

   task automatic t_wrap();
      do_reset();
      arm(0, 32'h6);
      arm(1, 32'h0500_0006);
      ev[5] = 1'b1; repeat (600) @(negedge clk); ev[5] = 1'b0;
      arm(0, 32'h6);
      ev[5] = 1'b1; repeat (500) @(negedge clk); ev[5] = 1'b0;
      chk_reg("R5 wraps modulo", a_cnt(1), 1100 % (1 << W));
      chk_reg("R5 own flag set", a_ctl(1), 32'h0500_0007);
      chk("R5 no interrupt", {31'b0, irq}, 0);
      chk_reg("R5 master flag clear", a_ctl(0), 32'h6);
   endtask

   task automatic t_overflow();
      do_reset();
      ev[8'h37] = 1'b1;
      arm(0, 32'h6);
      arm(1, 32'h3700_0006);
      repeat (1100) @(negedge clk);
      chk("R4 interrupt raised", {31'b0, irq}, 1);
      chk_reg("R4 master wrapped", a_cnt(0), 0);
      chk_reg("R4 master flag", a_ctl(0), 32'h7);
      chk_reg("R4 follower frozen", a_cnt(1), (1 << W) - 2);
      repeat (20) @(negedge clk);
      chk_reg("R4 still frozen", a_cnt(1), (1 << W) - 2);
      wr(a_ctl(0), 32'h7);
      chk("R6 writing one keeps irq", {31'b0, irq}, 1);
      wr(a_ctl(0), 32'h6);
      chk("R6 writing zero drops irq", {31'b0, irq}, 0);
      repeat (5) @(negedge clk);
      chk_reg("R4 master resumes", a_cnt(0), 5);
      chk_reg("R4 follower resumes", a_cnt(1), 3);
      chk_reg("R5 follower flag after wrap", a_ctl(1), 32'h3700_0007);
      ev[8'h37] = 1'b0;
   endtask

   initial begin
      t_reset_state();
      t_cycle();
      t_gate();
      t_filter();
      t_clear();
      t_wrap();
      t_overflow();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule